// File: doc/BRIEF.md
# Single-Upset-Tolerant Four-State Sequencer

This block is a small handshake controller that steps through four states: waiting, armed, running and finished. Each state is held in a 5-bit register whose legal codes are kept at least three bit flips apart from one another. Because of that spacing, a register value that has taken one stray bit flip is still closer to its original code than to any other legal code. The decoder therefore recognises the value as the intended state.

The decoded state drives the outputs and picks the next state exactly as the clean code would. On the following clock edge the register is rewritten with a clean code. The machine never falls back to reset after a single upset, so it stays in step with the logic it is shaking hands with. A `corrected` flag is high for every cycle in which the register holds a code that is not legal. An `upsetInj` port lets a test XOR an error pattern into the register, which models a radiation hit.

Top module: `hamming_ctrl`

## Requirements
- R1: Reset is asynchronous and active high. It loads the waiting code 5'b00000, and `ready` is then the only state output that is high. The other legal codes are armed 5'b00111, running 5'b11001 and finished 5'b11110.
- R2: In the waiting state with `start` high, the next edge enters armed. With `start` low it stays waiting.
- R3: Armed always moves to running on the next edge, and finished always moves to waiting on the next edge.
- R4: Running moves to finished on an edge where `finish` is high. Otherwise it stays running.
- R5: A register value within one bit of a legal code is decoded as that state, for both the outputs and the next-state choice.
- R6: A register value two or more bits away from every legal code is decoded as waiting.
- R7: `corrected` is high exactly while the register holds a non-legal code. After a single upset it lasts one cycle.
- R8: On every edge without injection, the register is loaded with the clean code of the decoded state's successor (scrubbing).
- R9: A nonzero `upsetInj` XORs its bits into the register at the edge in place of the normal transition. Reset takes priority over injection.
- R10: Exactly one of `ready`, `armed`, `running` and `complete` is high, and it is the one that matches the decoded state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| start | input | 1 | Request to leave waiting |
| finish | input | 1 | End of the running phase |
| upsetInj | input | 5 | Error pattern XORed into the state register (test only) |
| ready | output | 1 | Waiting state |
| armed | output | 1 | Armed state |
| running | output | 1 | Running state |
| complete | output | 1 | Finished state |
| corrected | output | 1 | Register holds a non-legal code |
| stateCode | output | 5 | Raw state register |

## Verification
On every clock, the assertions check four things: each legal transition and hold, the rule that one injected bit flip leaves the decoded state unchanged and raises `corrected`, the rule that a cycle without injection always leaves a clean code behind, and that exactly one state output is high. The bench's scenarios cover the remaining behaviour. They walk all 32 register values and check each against the nearest-code rule, including the far codes that fall to waiting. They check that the scrub writes the successor's clean code. They also show that reset wins over injection and that full sequences run unchanged through upsets in every state.

// File: rtl/hamming_ctrl_pkg.sv
package hamming_ctrl_pkg;

  localparam int STATE_W    = 5;
  localparam int NUM_STATES = 4;
  localparam int MAX_FIX    = 1;   // bit flips absorbed per legal code

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_GO   = 2'd2,
    ST_DONE = 2'd3
  } ctlState_e;

  typedef struct packed {
    logic      load;       // write a clean code this edge
    ctlState_e nextState;  // state whose code is written
  } ctlStrobe_t;

  function automatic logic [STATE_W-1:0] codeOf(input ctlState_e s);
    case (s)
      ST_IDLE: codeOf = 5'b00000;
      ST_ARM:  codeOf = 5'b00111;
      ST_GO:   codeOf = 5'b11001;
      default: codeOf = 5'b11110;
    endcase
  endfunction

endpackage

// File: rtl/hdc_state_store.sv
module hdc_state_store
  import hamming_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [STATE_W-1:0] upsetInj,
  input  ctlStrobe_t         strobe,
  output ctlState_e          decState,
  output logic               corrected,
  output logic [STATE_W-1:0] stateCode
);

  logic [STATE_W-1:0]    stateReg;
  logic [NUM_STATES-1:0] nearHit;
  logic [NUM_STATES-1:0] exactHit;

  // Distance of the register from each legal code
  for (genvar g = 0; g < NUM_STATES; g++) begin : g_dist
    localparam logic [STATE_W-1:0] LegalCode = codeOf(ctlState_e'(g));
    logic [STATE_W-1:0] diffBits;
    assign diffBits    = stateReg ^ LegalCode;
    assign nearHit[g]  = ($countones(diffBits) <= MAX_FIX);
    assign exactHit[g] = (diffBits == '0);
  end

  // Nearest legal neighbour; codes far from all fall back to idle
  always_comb begin
    decState = ST_IDLE;
    for (int i = NUM_STATES - 1; i >= 1; i--) begin
      if (nearHit[i]) decState = ctlState_e'(i);
    end
  end

  assign corrected = ~|exactHit;
  assign stateCode = stateReg;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stateReg <= codeOf(ST_IDLE);
    end else if (|upsetInj) begin
      stateReg <= stateReg ^ upsetInj;
    end else if (strobe.load) begin
      stateReg <= codeOf(strobe.nextState);
    end
  end

  AST_NEAR_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    $countones(nearHit) <= 1);  // R5

  AST_CLEAN_AFTER_SCRUB: assert property (@(posedge clk) disable iff (rst)
    (upsetInj == '0 && strobe.load) |=> (stateCode == codeOf($past(strobe.nextState))));  // R8

endmodule

// File: rtl/hdc_sequencer.sv
module hdc_sequencer
  import hamming_ctrl_pkg::*;
(
  input  ctlState_e  decState,
  input  logic       start,
  input  logic       finish,
  output ctlStrobe_t strobe,
  output logic       ready,
  output logic       armed,
  output logic       running,
  output logic       complete
);

  always_comb begin
    strobe.load      = 1'b1;
    strobe.nextState = decState;
    case (decState)
      ST_IDLE: if (start)  strobe.nextState = ST_ARM;
      ST_ARM:  strobe.nextState = ST_GO;
      ST_GO:   if (finish) strobe.nextState = ST_DONE;
      default: strobe.nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    ready    = (decState == ST_IDLE);
    armed    = (decState == ST_ARM);
    running  = (decState == ST_GO);
    complete = (decState == ST_DONE);
  end

endmodule

// File: rtl/hamming_ctrl.sv
module hamming_ctrl
  import hamming_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               finish,
  input  logic [STATE_W-1:0] upsetInj,
  output logic               ready,
  output logic               armed,
  output logic               running,
  output logic               complete,
  output logic               corrected,
  output logic [STATE_W-1:0] stateCode
);

  ctlState_e  decState;
  ctlStrobe_t strobe;

  hdc_state_store u_store (
    .clk       (clk),
    .rst       (rst),
    .upsetInj  (upsetInj),
    .strobe    (strobe),
    .decState  (decState),
    .corrected (corrected),
    .stateCode (stateCode)
  );

  hdc_sequencer u_seq (
    .decState (decState),
    .start    (start),
    .finish   (finish),
    .strobe   (strobe),
    .ready    (ready),
    .armed    (armed),
    .running  (running),
    .complete (complete)
  );

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ready && !start && upsetInj == '0) |=> (ready && !corrected));  // R2

  AST_IDLE_START: assert property (@(posedge clk) disable iff (rst)
    (ready && start && upsetInj == '0) |=> armed);  // R2

  AST_ARM_TO_GO: assert property (@(posedge clk) disable iff (rst)
    (armed && upsetInj == '0) |=> running);  // R3

  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (complete && upsetInj == '0) |=> ready);  // R3

  AST_GO_STEP: assert property (@(posedge clk) disable iff (rst)
    (running && upsetInj == '0) |=> (finish ? complete : running) or $past(finish) ? complete : running);  // R4

  AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
    ($countones(upsetInj) == 1 && !corrected) |=> (corrected && decState == $past(decState)));  // R5

  AST_SCRUB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (upsetInj == '0) |=> !corrected);  // R7

  AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    $countones({ready, armed, running, complete}) == 1);  // R10

endmodule

// File: tb/sim_hamming_ctrl.sv
module sim_hamming_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       finish = 1'b0;
  logic [4:0] upsetInj = 5'b0;
  logic       ready, armed, running, complete, corrected;
  logic [4:0] stateCode;

  int checks = 0;
  int fails  = 0;
  bit over   = 1'b0;

  always #5 clk = ~clk;

  hamming_ctrl u0 (
    .clk(clk), .rst(rst), .start(start), .finish(finish), .upsetInj(upsetInj),
    .ready(ready), .armed(armed), .running(running), .complete(complete),
    .corrected(corrected), .stateCode(stateCode)
  );

  // Legal codes from R1: 0 idle, 1 arm, 2 go, 3 done
  function automatic logic [4:0] legalCode(input int s);
    case (s)
      0: legalCode = 5'b00000;
      1: legalCode = 5'b00111;
      2: legalCode = 5'b11001;
      default: legalCode = 5'b11110;
    endcase
  endfunction

  // R5 / R6: nearest code within one flip, else idle
  function automatic int nearest(input logic [4:0] c);
    nearest = 0;
    for (int i = 1; i < 4; i++)
      if ($countones(c ^ legalCode(i)) <= 1) nearest = i;
  endfunction

  function automatic bit isLegal(input logic [4:0] c);
    isLegal = 1'b0;
    for (int i = 0; i < 4; i++)
      if (c == legalCode(i)) isLegal = 1'b1;
  endfunction

  function automatic int idleStep(input int s);
    case (s)
      0: idleStep = 0;
      1: idleStep = 2;
      2: idleStep = 2;
      default: idleStep = 0;
    endcase
  endfunction

  function automatic int seenState();
    seenState = armed ? 1 : running ? 2 : complete ? 3 : 0;
  endfunction

  task automatic checkAll(input string req, input int expSt, input bit expCorr,
                          input logic [4:0] expCode);
    checks++;
    if ($countones({ready, armed, running, complete}) != 1 || seenState() != expSt ||
        corrected != expCorr || stateCode != expCode) begin
      fails++;
      $display("FAIL %s: state=%0d corr=%0b code=%05b outs=%04b, expected state=%0d corr=%0b code=%05b",
               req, seenState(), corrected, stateCode, {ready, armed, running, complete},
               expSt, expCorr, expCode);
    end
  endtask

  // {start, finish, inj[4:0], expState[1:0], expCorr}
  localparam logic [9:0] VEC [0:15] = '{
    {1'b0, 1'b0, 5'b00000, 2'd0, 1'b0},  // R2 hold idle
    {1'b1, 1'b0, 5'b00000, 2'd1, 1'b0},  // R2 start
    {1'b0, 1'b0, 5'b00000, 2'd2, 1'b0},  // R3 arm->go
    {1'b0, 1'b0, 5'b00000, 2'd2, 1'b0},  // R4 hold go
    {1'b0, 1'b1, 5'b00000, 2'd3, 1'b0},  // R4 finish
    {1'b0, 1'b0, 5'b00000, 2'd0, 1'b0},  // R3 done->idle
    {1'b0, 1'b0, 5'b00100, 2'd0, 1'b1},  // R5 flip in idle
    {1'b1, 1'b0, 5'b00000, 2'd1, 1'b0},  // R8 scrub to arm
    {1'b0, 1'b0, 5'b00001, 2'd1, 1'b1},  // R5 flip in arm
    {1'b0, 1'b0, 5'b00000, 2'd2, 1'b0},  // R8 scrub to go
    {1'b0, 1'b0, 5'b10000, 2'd2, 1'b1},  // R5 flip in go
    {1'b0, 1'b0, 5'b00000, 2'd2, 1'b0},  // R7 flag lasts one cycle
    {1'b0, 1'b0, 5'b00010, 2'd2, 1'b1},  // R9 injection overrides hold
    {1'b0, 1'b1, 5'b00000, 2'd3, 1'b0},  // R8 scrub to done
    {1'b0, 1'b0, 5'b01000, 2'd3, 1'b1},  // R5 flip in done
    {1'b0, 1'b0, 5'b00000, 2'd0, 1'b0}   // R3 done->idle after flip
  };

  initial begin
    #2_000_000;
    if (!over) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    checkAll("R1 reset state", 0, 1'b0, 5'b00000);
    rst = 1'b0;

    for (int v = 0; v < 16; v++) begin
      start    = VEC[v][9];
      finish   = VEC[v][8];
      upsetInj = VEC[v][7:3];
      @(negedge clk);
      checkAll($sformatf("R5/R8 vector %0d", v), int'(VEC[v][2:1]), VEC[v][0],
               VEC[v][0] ? (legalCode(int'(VEC[v][2:1])) ^ VEC[v][7:3])
                         : legalCode(int'(VEC[v][2:1])));
      start = 1'b0; finish = 1'b0; upsetInj = 5'b0;
    end

    // R9: reset wins over injection
    rst = 1'b1; upsetInj = 5'b10101;
    @(negedge clk);
    checkAll("R9 reset over injection", 0, 1'b0, 5'b00000);
    upsetInj = 5'b0;
    rst = 1'b0;

    // R6: far code 01010 acts as idle, start still arms
    upsetInj = 5'b01010;
    @(negedge clk);
    upsetInj = 5'b0;
    checkAll("R6 far code decodes idle", 0, 1'b1, 5'b01010);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    checkAll("R6 far code then start", 1, 1'b0, 5'b00111);

    // R5/R6/R7/R8: every register value
    for (int c = 0; c < 32; c++) begin
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      upsetInj = 5'(c);
      @(negedge clk);
      upsetInj = 5'b0;
      checkAll($sformatf("R5/R6 code %05b decode", 5'(c)), nearest(5'(c)),
               !isLegal(5'(c)), 5'(c));
      @(negedge clk);
      checkAll($sformatf("R7/R8 code %05b scrub", 5'(c)), idleStep(nearest(5'(c))),
               1'b0, legalCode(idleStep(nearest(5'(c)))));
    end

    over = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule